// File: doc/BRIEF.md
# Source-Routed Turn Pool Port Selector

This block sits in the ingress pipeline of an 8-port fabric switch. It picks the egress port of a unicast packet from the path that the sender wrote into the header, so the switch holds no routing table and needs no software. The header arrives as one parallel word with three parts: the turn pool (the whole source route), a turn pointer that counts the route bits still unused, and the port the packet came in on. The block takes this switch's turn from the top of the unused bits. It turns that relative turn into an absolute output port, counted from the arrival port. It moves the pointer past the bits it used. In their place it writes the turn that leads back to the sender, so a response header can later retrace the path without software.

The number of bits per turn is a plain configuration input. Each switch region can therefore use its own turn width (a full 8-port region takes 3 bits, smaller regions take fewer), and the pointer moves by a variable amount at each hop. Headers that cannot be routed are dropped and flagged: a pointer with too few bits left, a bad turn width, or a turn that would send the packet back out of its arrival port.

Headers enter and leave through valid/ready streams. Back-pressure rules: the input takes a header only on a cycle with `in_valid` and `in_ready` both high. A result stays on the output, unchanged, until a cycle with `out_ready` high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A single register stage therefore gives one header per cycle while `out_ready` stays high.

Top module: `turn_port_selector`

## Requirements
- R1: After reset, `out_valid` and `route_err` are 0 and `in_ready` is 1.
- R2: With k = `cfg_turn_bits`, the turn t is pool bits [ptr-1 : ptr-k], where bit ptr-1 is the turn's MSB. The egress `out_port` is (in_port + t + 1) mod 2^k.
- R3: `out_ptr` equals the input pointer minus k.
- R4: `out_pool` holds the reverse turn (2^k - t - 2) mod 2^k in bits [ptr-1 : ptr-k]. Every other pool bit is unchanged.
- R5: A pointer below k or above the pool width (32 by default) drops the header. `route_err` is then high for exactly the one cycle after the accepting edge, and no output is presented.
- R6: A turn of all ones in its k bits (the value that would select the arrival port) drops the header with `route_err`, as in R5.
- R7: A turn width k of 0, or above 3, drops every header with `route_err`.
- R8: A header is taken only when `in_valid` and `in_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds and `in_ready` is 0.
- R9: A routable header taken at edge n shows on the outputs with `out_valid` high from edge n onward. With `out_ready` held high, headers stream at one per cycle.
- R10: `out_port` never equals `out_src_port` while `out_valid` is high.
- R11: `out_src_port` carries the arrival port of the header being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_turn_bits | input | 2 | Turn width k used by this switch region |
| in_valid | input | 1 | Input header valid |
| in_ready | output | 1 | Block can take a header |
| in_pool | input | 32 | Turn pool field |
| in_ptr | input | 6 | Count of route bits not yet used |
| in_port | input | 3 | Arrival port |
| out_valid | output | 1 | Routed header valid |
| out_ready | input | 1 | Downstream takes the routed header |
| out_pool | output | 32 | Turn pool with the reverse turn written in |
| out_ptr | output | 6 | Pointer after this hop |
| out_port | output | 3 | Selected egress port |
| out_src_port | output | 3 | Arrival port of the presented header |
| route_err | output | 1 | One-cycle pulse: the header taken on the last edge was dropped |

## Verification
Every result, whether a routed header or a `route_err` pulse, is due one clock edge after the edge that accepts the header. The bench drives inputs on falling edges and reads the outputs at the falling edge that follows the accepting rising edge. In the stall test, the held output and the low `in_ready` are read at each falling edge for several cycles. The header offered during the stall is then looked for only at the falling edge after `out_ready` returns, which is one edge later. In the streaming test, each falling edge checks the header driven one cycle earlier.

// File: rtl/turnsel_pkg.sv
package turnsel_pkg;

  typedef enum logic [1:0] {
    RS_OK       = 2'd0,
    RS_BAD_CFG  = 2'd1,
    RS_BAD_PTR  = 2'd2,
    RS_LOOPBACK = 2'd3
  } route_status_e;

  function automatic route_status_e classify(input logic cfg_bad,
                                             input logic ptr_bad,
                                             input logic loopback);
    if (cfg_bad)       return RS_BAD_CFG;
    else if (ptr_bad)  return RS_BAD_PTR;
    else if (loopback) return RS_LOOPBACK;
    else               return RS_OK;
  endfunction

endpackage

// File: rtl/turn_extract.sv
module turn_extract #(
  parameter int POOL_W = 32,
  parameter int TURN_W = 3,
  parameter int PTR_W  = 6,
  parameter int TBW    = 2
) (
  input  logic [POOL_W-1:0] pool,
  input  logic [PTR_W-1:0]  ptr,
  input  logic [TBW-1:0]    turn_bits,
  output logic [TURN_W-1:0] field_mask,
  output logic [TURN_W-1:0] turn,
  output logic [PTR_W-1:0]  lo,
  output logic              cfg_bad,
  output logic              ptr_bad
);
  logic [PTR_W-1:0] k_ext;
  assign k_ext = PTR_W'(turn_bits);

  // one mask bit per possible turn bit: set when the region uses it
  for (genvar i = 0; i < TURN_W; i++) begin : g_mask
    assign field_mask[i] = (32'(turn_bits) > 32'(i));
  end

  assign cfg_bad = (turn_bits == '0) || (32'(turn_bits) > 32'(TURN_W));
  assign ptr_bad = (ptr < k_ext) || (32'(ptr) > 32'(POOL_W));
  assign lo      = ptr - k_ext;
  assign turn    = TURN_W'(pool >> lo) & field_mask;
endmodule

// File: rtl/turn_port_map.sv
module turn_port_map #(
  parameter int TURN_W = 3
) (
  input  logic [TURN_W-1:0] in_port,
  input  logic [TURN_W-1:0] turn,
  input  logic [TURN_W-1:0] field_mask,
  output logic [TURN_W-1:0] egress,
  output logic [TURN_W-1:0] rev_turn,
  output logic              loopback
);
  localparam logic [TURN_W-1:0] ONE = TURN_W'(1);

  // relative turn counted from the port after the arrival port
  assign egress   = (in_port + turn + ONE) & field_mask;
  // -t-2 == ~t-1 in two's complement, then reduced to the region width
  assign rev_turn = (~turn - ONE) & field_mask;
  // all-ones turn wraps back onto the arrival port
  assign loopback = (turn == field_mask);
endmodule

// File: rtl/turn_pool_rewrite.sv
module turn_pool_rewrite #(
  parameter int POOL_W = 32,
  parameter int TURN_W = 3,
  parameter int PTR_W  = 6
) (
  input  logic [POOL_W-1:0] pool,
  input  logic [TURN_W-1:0] rev_turn,
  input  logic [TURN_W-1:0] field_mask,
  input  logic [PTR_W-1:0]  lo,
  output logic [POOL_W-1:0] new_pool
);
  logic [POOL_W-1:0] wide_mask;
  logic [POOL_W-1:0] wide_val;

  assign wide_mask = POOL_W'(field_mask) << lo;
  assign wide_val  = POOL_W'(rev_turn) << lo;

  for (genvar b = 0; b < POOL_W; b++) begin : g_bit
    assign new_pool[b] = wide_mask[b] ? wide_val[b] : pool[b];
  end
endmodule

// File: rtl/turn_hold_stage.sv
module turn_hold_stage #(
  parameter int DATA_W = 44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              good,
  input  logic [DATA_W-1:0] d_in,
  input  logic              drain,
  output logic              vld,
  output logic              err,
  output logic [DATA_W-1:0] d_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      err   <= 1'b0;
      d_out <= '0;
    end else begin
      err <= take && !good;
      if (take && good) begin
        vld   <= 1'b1;
        d_out <= d_in;
      end else if (drain) begin
        vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/turn_port_selector.sv
module turn_port_selector #(
  parameter int POOL_W    = 32,
  parameter int NUM_PORTS = 8,
  localparam int TURN_W   = $clog2(NUM_PORTS),
  localparam int PTR_W    = $clog2(POOL_W + 1),
  localparam int TBW      = $clog2(TURN_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TBW-1:0]    cfg_turn_bits,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [POOL_W-1:0] in_pool,
  input  logic [PTR_W-1:0]  in_ptr,
  input  logic [TURN_W-1:0] in_port,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [POOL_W-1:0] out_pool,
  output logic [PTR_W-1:0]  out_ptr,
  output logic [TURN_W-1:0] out_port,
  output logic [TURN_W-1:0] out_src_port,
  output logic              route_err
);
  import turnsel_pkg::*;

  localparam int DATA_W = POOL_W + PTR_W + 2 * TURN_W;

  logic [TURN_W-1:0] field_mask, turn, egress, rev_turn;
  logic [PTR_W-1:0]  lo;
  logic              cfg_bad, ptr_bad, loopback, take, good;
  logic [POOL_W-1:0] new_pool;
  logic [DATA_W-1:0] d_in, d_out;
  route_status_e     status;

  turn_extract #(.POOL_W(POOL_W), .TURN_W(TURN_W), .PTR_W(PTR_W), .TBW(TBW)) u_extract (
    .pool(in_pool), .ptr(in_ptr), .turn_bits(cfg_turn_bits),
    .field_mask(field_mask), .turn(turn), .lo(lo),
    .cfg_bad(cfg_bad), .ptr_bad(ptr_bad)
  );

  turn_port_map #(.TURN_W(TURN_W)) u_map (
    .in_port(in_port), .turn(turn), .field_mask(field_mask),
    .egress(egress), .rev_turn(rev_turn), .loopback(loopback)
  );

  turn_pool_rewrite #(.POOL_W(POOL_W), .TURN_W(TURN_W), .PTR_W(PTR_W)) u_rewrite (
    .pool(in_pool), .rev_turn(rev_turn), .field_mask(field_mask),
    .lo(lo), .new_pool(new_pool)
  );

  assign status   = classify(cfg_bad, ptr_bad, loopback);
  assign good     = (status == RS_OK);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign d_in     = {new_pool, lo, egress, in_port};

  turn_hold_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .take(take), .good(good), .d_in(d_in),
    .drain(out_ready), .vld(out_valid), .err(route_err), .d_out(d_out)
  );

  assign {out_pool, out_ptr, out_port, out_src_port} = d_out;
endmodule

// File: rtl/turn_port_selector_chk.sv
module turn_port_selector_chk #(
  parameter int POOL_W = 32,
  parameter int PTR_W  = 6,
  parameter int TURN_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [POOL_W-1:0] out_pool,
  input logic [PTR_W-1:0]  out_ptr,
  input logic [TURN_W-1:0] out_port,
  input logic [TURN_W-1:0] out_src_port,
  input logic              route_err
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pool) && $stable(out_ptr)
                                   && $stable(out_port) && $stable(out_src_port)));

  // R9
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid ^ route_err));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route_err |-> $past(in_valid && in_ready));

  // R10
  no_loopback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_port != out_src_port));
endmodule

bind turn_port_selector turn_port_selector_chk #(
  .POOL_W(POOL_W), .PTR_W(PTR_W), .TURN_W(TURN_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pool(out_pool),
  .out_ptr(out_ptr), .out_port(out_port), .out_src_port(out_src_port),
  .route_err(route_err)
);

// File: tb/turn_port_selector_tb_top.sv
module turn_port_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_turn_bits = 2'd3;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pool = '0;
  logic [5:0]  in_ptr = '0;
  logic [2:0]  in_port = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_pool;
  logic [5:0]  out_ptr;
  logic [2:0]  out_port;
  logic [2:0]  out_src_port;
  logic        route_err;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  turn_port_selector dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_turn_bits(cfg_turn_bits),
    .in_valid(in_valid), .in_ready(in_ready), .in_pool(in_pool),
    .in_ptr(in_ptr), .in_port(in_port), .out_valid(out_valid),
    .out_ready(out_ready), .out_pool(out_pool), .out_ptr(out_ptr),
    .out_port(out_port), .out_src_port(out_src_port), .route_err(route_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // expected result from the requirements
  task automatic model(input int k, input logic [31:0] pool, input int ptr, input int port,
                       output bit bad, output string why, output logic [31:0] ep,
                       output int eptr, output int eg);
    logic [31:0] m;
    int lo, t;
    m = (32'd1 << k) - 32'd1;
    bad = 1'b0; why = "R9"; ep = pool; eptr = 0; eg = 0;
    if (k == 0 || k > 3) begin bad = 1'b1; why = "R7"; end
    else if (ptr < k || ptr > 32) begin bad = 1'b1; why = "R5"; end
    else begin
      lo = ptr - k;
      t = int'((pool >> lo) & m);
      if (t == int'(m)) begin bad = 1'b1; why = "R6"; end
      else begin
        eg = (port + t + 1) % (1 << k);
        ep = (pool & ~(m << lo)) | (32'((1 << k) - t - 2) << lo);
        eptr = ptr - k;
      end
    end
  endtask

  task automatic compare(input bit bad, input string why, input logic [31:0] ep,
                         input int eptr, input int eg, input int port);
    if (bad) begin
      check({why, " dropped: out_valid"}, 64'(out_valid), 64'd0);
      check({why, " dropped: route_err"}, 64'(route_err), 64'd1);
    end else begin
      check("R9 out_valid", 64'(out_valid), 64'd1);
      check("R9 route_err", 64'(route_err), 64'd0);
      check("R2 egress", 64'(out_port), 64'(eg));
      check("R3 pointer", 64'(out_ptr), 64'(eptr));
      check("R4 pool", 64'(out_pool), 64'(ep));
      check("R11 src port", 64'(out_src_port), 64'(port));
      check("R10 no loopback", 64'(out_port != out_src_port), 64'd1);
    end
  endtask

  task automatic one_shot(input int k, input logic [31:0] pool, input int ptr, input int port);
    bit bad; string why; logic [31:0] ep; int eptr, eg;
    model(k, pool, ptr, port, bad, why, ep, eptr, eg);
    @(negedge clk);
    cfg_turn_bits = 2'(k); in_pool = pool; in_ptr = 6'(ptr); in_port = 3'(port);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(bad, why, ep, eptr, eg, port);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] pool_a, pool_b;
    bit bad; string why; logic [31:0] ep; int eptr, eg;
    logic [31:0] s_pool [10];
    int s_ptr [10];
    int s_port [10];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 out_valid", 64'(out_valid), 64'd0);
    check("R1 route_err", 64'(route_err), 64'd0);
    check("R1 in_ready", 64'(in_ready), 64'd1);

    // sweep: turn width, pointer, arrival port, turn value (R2..R7, R10, R11)
    for (int k = 0; k <= 3; k++) begin
      for (int ptr = 0; ptr <= 34; ptr++) begin
        for (int port = 0; port < 8; port++) begin
          for (int t = 0; t < (1 << k); t++) begin
            logic [31:0] m;
            int lo;
            if ((k == 0 || ptr < k || ptr > 32) && t != 0) continue;
            seed = next_rand(seed);
            pool_a = seed;
            if (k > 0 && ptr >= k && ptr <= 32) begin
              lo = ptr - k;
              m = (32'd1 << k) - 32'd1;
              pool_a = (pool_a & ~(m << lo)) | (32'(t) << lo);
            end
            one_shot(k, pool_a, ptr, port);
          end
        end
      end
    end

    // R8 stall: hold output, refuse a second header
    pool_a = 32'hA5A5_0F0F;
    pool_b = 32'h0123_4567;
    @(negedge clk);
    cfg_turn_bits = 2'd3; in_pool = pool_a; in_ptr = 6'd9; in_port = 3'd2;
    in_valid = 1'b1; out_ready = 1'b0;
    model(3, pool_a, 9, 2, bad, why, ep, eptr, eg);
    @(negedge clk);
    in_pool = pool_b; in_ptr = 6'd20; in_port = 3'd6;
    for (int c = 0; c < 4; c++) begin
      check("R8 held valid", 64'(out_valid), 64'd1);
      check("R8 held pool", 64'(out_pool), 64'(ep));
      check("R8 held port", 64'(out_port), 64'(eg));
      check("R8 held src", 64'(out_src_port), 64'd2);
      check("R8 in_ready low", 64'(in_ready), 64'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    model(3, pool_b, 20, 6, bad, why, ep, eptr, eg);
    @(negedge clk);
    in_valid = 1'b0;
    compare(bad, why, ep, eptr, eg, 6);
    @(negedge clk);
    check("R8 drained", 64'(out_valid), 64'd0);

    // R9 streaming at one per cycle
    for (int j = 0; j < 10; j++) begin
      seed = next_rand(seed);
      s_pool[j] = seed & 32'hFFFF_FFBF; // keep a usable pattern mix
      s_ptr[j]  = 3 + (j * 3) % 30;
      s_port[j] = j % 8;
    end
    for (int j = 0; j <= 10; j++) begin
      @(negedge clk);
      if (j > 0) begin
        model(3, s_pool[j-1], s_ptr[j-1], s_port[j-1], bad, why, ep, eptr, eg);
        compare(bad, why, ep, eptr, eg, s_port[j-1]);
      end
      if (j < 10) begin
        cfg_turn_bits = 2'd3; in_pool = s_pool[j]; in_ptr = 6'(s_ptr[j]);
        in_port = 3'(s_port[j]); in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R9 stream end", 64'(out_valid), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule